// File: doc/BRIEF.md
# Shared legacy and message interrupt status unit

This block merges four level-sensitive legacy interrupt lines and a single "message pending" summary flag into one status word, masks that word with an enable word, and raises a single interrupt request to the host. Each legacy line sets a sticky status bit. Software clears a sticky bit by writing a one to it. If the line is still high, the bit comes back on the next cycle. A handler therefore clears, reads again, and repeats until the legacy bits read zero.

The message bit is not stored in the unit. It mirrors an external not-empty flag from a message queue, so it drops when that queue has been drained. The enable word can be written whole, or single bits can be set or cleared through two dedicated addresses, without a read-modify-write. At reset every implemented source is enabled.

Register map (word address on `reg_addr`): 0 holds the raw status, 1 holds the enable word, 2 is the set-enable strobe and 3 is the clear-enable strobe. Reads of addresses 2 and 3 return zero.

Top module: `intr_status_unit`

## Requirements
- R1: After reset the legacy status bits are zero, `irq_out` is low, and the enable word reads 0x0000_01E8, meaning bits 3 and 5..8 are set.
- R2: While legacy line n (n = 0..3) is high at a clock edge, status bit 5+n is set at that edge. It stays set after the line drops until software clears it.
- R3: A write to address 0 clears every legacy status bit whose data bit is one. Bits whose data bit is zero keep their value. Data bit 3 has no effect.
- R4: A clear that hits a line which is still high leaves the bit at zero for exactly one cycle. The bit is set again at the following edge.
- R5: Status bit 3 always equals the current `msi_pending` input and is never latched.
- R6: `irq_out` equals the OR of (raw status AND enable) as it stood at the previous clock edge. It is registered with one cycle of delay.
- R7: A write to address 1 loads the enable word. Only bits 3 and 5..8 are stored; all other bits read zero.
- R8: A write to address 2 sets the enable bits where the data is one. A write to address 3 clears the enable bits where the data is one. All other enable bits keep their value.
- R9: A source whose enable bit is zero still shows in the raw status but does not raise `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intx_lvl | input | 4 | Legacy interrupt levels, one per line |
| msi_pending | input | 1 | Not-empty flag of the message queue |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: 32-bit words, four legacy lines starting at bit 5, and the message bit at bit 3. With these values the whole status word fits in one read, so clearing, re-latching and masking can all be observed in the same word on consecutive cycles. A pseudo-random phase mixes line changes with writes to all four addresses. That phase reaches the case where a clear coincides with a still-high line, and also enable changes that land in the same cycle as a new source.

// File: rtl/intr_status_unit.sv
module intr_status_unit #(
  parameter int DW       = 32,
  parameter int AW       = 2,
  parameter int N_INTX   = 4,
  parameter int INTX_LSB = 5,
  parameter int MSI_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INTX-1:0] intx_lvl,
  input  logic              msi_pending,
  input  logic              reg_wen,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_out
);
  localparam logic [DW-1:0] ONE       = DW'(1);
  localparam logic [DW-1:0] INTX_MASK = ((ONE << N_INTX) - ONE) << INTX_LSB;
  localparam logic [DW-1:0] MSI_MASK  = ONE << MSI_BIT;
  localparam logic [DW-1:0] EN_MASK   = INTX_MASK | MSI_MASK;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_SET  = AW'(2);
  localparam logic [AW-1:0] A_CLR  = AW'(3);

  logic [N_INTX-1:0] stat_q;
  logic [DW-1:0]     en_q;
  logic [DW-1:0]     raw_w;
  logic [N_INTX-1:0] clr_w;
  logic [DW-1:0]     wmask_w;
  logic              irq_q;

  assign raw_w   = (DW'(stat_q) << INTX_LSB) | (DW'(msi_pending) << MSI_BIT);
  assign clr_w   = (reg_wen && reg_addr == A_STAT) ? reg_wdata[INTX_LSB +: N_INTX] : '0;
  assign wmask_w = reg_wdata & EN_MASK;
  assign irq_out = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= EN_MASK;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q | intx_lvl) & ~clr_w;
      irq_q  <= |(raw_w & en_q);
      if (reg_wen) begin
        case (reg_addr)
          A_EN:    en_q <= wmask_w;
          A_SET:   en_q <= en_q | wmask_w;
          A_CLR:   en_q <= en_q & ~wmask_w;
          default: en_q <= en_q;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = raw_w;
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module intr_status_unit_chk #(
  parameter int DW       = 32,
  parameter int AW       = 2,
  parameter int N_INTX   = 4,
  parameter int INTX_LSB = 5,
  parameter int MSI_BIT  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_INTX-1:0] intx_lvl,
  input logic              msi_pending,
  input logic              reg_wen,
  input logic [AW-1:0]     reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              irq_out,
  input logic [N_INTX-1:0] stat_q,
  input logic [DW-1:0]     en_q,
  input logic [DW-1:0]     raw_w
);
  logic              armed;
  logic [N_INTX-1:0] clrm;
  logic [DW-1:0]     setm;

  assign clrm = (reg_wen && reg_addr == AW'(0)) ? reg_wdata[INTX_LSB +: N_INTX] : '0;
  assign setm = (reg_wen && reg_addr == AW'(2)) ?
                (reg_wdata & ((((DW'(1) << N_INTX) - DW'(1)) << INTX_LSB) | (DW'(1) << MSI_BIT))) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R2
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(intx_lvl & ~clrm)) == $past(intx_lvl & ~clrm)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrm != '0) |=> ((stat_q & $past(clrm)) == '0));

  // R5
  msi_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(0)) |-> (reg_rdata[MSI_BIT] == msi_pending));

  // R6
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_out == |$past(raw_w & en_q)));

  // R8
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setm != '0) |=> ((en_q & $past(setm)) == $past(setm)));
endmodule

bind intr_status_unit intr_status_unit_chk #(
  .DW(DW), .AW(AW), .N_INTX(N_INTX), .INTX_LSB(INTX_LSB), .MSI_BIT(MSI_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .msi_pending(msi_pending),
  .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_out(irq_out), .stat_q(stat_q), .en_q(en_q),
  .raw_w(raw_w)
);

// File: tb/sim_intr_status_unit.sv
module sim_intr_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_lvl = '0;
  logic        msi_pending = 1'b0;
  logic        reg_wen = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int          m_st[4];
  logic [31:0] m_en;
  logic        m_irq;

  always #2.5 clk = ~clk;

  intr_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .msi_pending(msi_pending),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] m_raw();
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (m_st[i] != 0) r[5+i] = 1'b1;
    r[3] = msi_pending;
    return r;
  endfunction

  function automatic logic [31:0] m_read();
    if (reg_addr == 2'd0) return m_raw();
    if (reg_addr == 2'd1) return m_en;
    return 32'h0;
  endfunction

  task automatic cmp(string tag);
    n_vec++;
    if (reg_rdata !== m_read()) begin
      n_bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, reg_addr, reg_rdata, m_read());
    end
    n_vec++;
    if (irq_out !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, m_irq);
    end
  endtask

  task automatic step(string tag, logic [3:0] lvl, logic msi, logic wen,
                      logic [1:0] addr, logic [31:0] wd);
    logic [31:0] valid;
    intx_lvl = lvl; msi_pending = msi; reg_wen = wen; reg_addr = addr; reg_wdata = wd;
    @(posedge clk);
    valid = 32'h0000_01E8;
    m_irq = |(m_raw() & m_en);
    for (int i = 0; i < 4; i++) begin
      if (lvl[i]) m_st[i] = 1;
      if (wen && addr == 2'd0 && wd[5+i]) m_st[i] = 0;
    end
    if (wen && addr == 2'd1) m_en = wd & valid;
    if (wen && addr == 2'd2) m_en = m_en | (wd & valid);
    if (wen && addr == 2'd3) m_en = m_en & ~(wd & valid);
    @(negedge clk);
    reg_wen = 1'b0;
    cmp(tag);
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) m_st[i] = 0;
    m_en = 32'h0000_01E8;
    m_irq = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1 reset status");
    reg_addr = 2'd1; #1;
    cmp("R1 reset enable");
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 2'd0;

    // R2 latch then hold
    step("R2 set", 4'b0001, 0, 0, 2'd0, 0);
    step("R2 sticky", 4'b0000, 0, 0, 2'd0, 0);
    step("R6 irq", 4'b0000, 0, 0, 2'd0, 0);
    // R3 write zero, write bit3, write one
    step("R3 zero write", 4'b0000, 1, 1, 2'd0, 32'h0);
    step("R3 bit3 write", 4'b0000, 1, 1, 2'd0, 32'h8);
    step("R3 clear", 4'b0000, 0, 1, 2'd0, 32'h20);
    step("R3 after", 4'b0000, 0, 0, 2'd0, 0);
    // R4 re-latch
    step("R4 hold", 4'b0010, 0, 0, 2'd0, 0);
    step("R4 clear", 4'b0010, 0, 1, 2'd0, 32'h40);
    step("R4 relatch", 4'b0010, 0, 0, 2'd0, 0);
    step("R4 clear2", 4'b0000, 0, 1, 2'd0, 32'h1E0);
    step("R4 empty", 4'b0000, 0, 0, 2'd0, 0);
    // R5 live message bit
    step("R5 up", 4'b0000, 1, 0, 2'd0, 0);
    step("R5 down", 4'b0000, 0, 0, 2'd0, 0);
    // R7 full enable write
    step("R7 all ones", 4'b0000, 0, 1, 2'd1, 32'hFFFF_FFFF);
    step("R7 zero", 4'b0000, 0, 1, 2'd1, 32'h0);
    // R9 masked source visible, no irq
    step("R9 masked", 4'b1000, 1, 0, 2'd0, 0);
    step("R9 masked2", 4'b1000, 1, 0, 2'd0, 0);
    // R8 set/clear
    step("R8 set", 4'b0000, 1, 1, 2'd2, 32'h0000_0108);
    step("R8 read", 4'b0000, 1, 0, 2'd1, 0);
    step("R8 clr", 4'b0000, 1, 1, 2'd3, 32'h0000_0008);
    step("R8 read2", 4'b0000, 1, 0, 2'd1, 0);
    step("R8 irq", 4'b0000, 0, 0, 2'd0, 0);
    step("R8 strobe read", 4'b0000, 0, 0, 2'd2, 0);

    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R6 mixed", lf[3:0], lf[4], lf[5], lf[7:6], {lf, lf} & 32'h0000_01FF);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule